// File: doc/BRIEF.md
# Outstanding Memory Request Tracker

This block sits between one processor port and its cache controller and keeps account of every memory request still in flight. Each incoming request carries an address and a kind code. The block sorts it into a read-side table or a write-side table, and keys the entry by cache-line address, which is the request address with its block-offset bits cleared. In the same cycle it returns a verdict. A request whose line is already in flight is refused as aliased, because same-line requests are never merged. A request is also refused when the tracker has no room, either because the runtime limit on in-flight requests is reached or because the chosen table has no free slot. Every other request is accepted and logged with a timestamp from a free-running cycle counter.

Completion strobes, one for reads and one for writes, retire the matching entry. A completion and a new request may fall in the same cycle, and the completion takes effect first. Four saturating counters record aliasing refusals, split by the table that was hit and by the kind of the refused request. A completion that names a line with no entry raises a sticky protocol-error flag and changes nothing else.

A small watchdog state machine guards against hangs. In WD_IDLE no request is in flight. The arm transition goes to WD_RUN as soon as the occupancy is non-zero. WD_RUN counts out one threshold period, and the expire transition then leads to WD_SCAN. WD_SCAN spends one cycle comparing the age of every valid entry with the threshold, and any entry at or past it sets a sticky deadlock flag. From WD_SCAN the rearm transition returns to WD_RUN while requests remain, and the settle transition returns to WD_IDLE when none remain.

Top module: `req_tracker`

## Requirements
- R1: Kind codes are 0 load, 1 instruction fetch, 2 store, 3 read-modify-write read, 4 read-modify-write write, 5 locked read and 6 locked write. Codes 2 to 6 go to the write-side table and are retired only by the write completion. Codes 0 and 1 go to the read-side table and are retired only by the read completion.
- R2: Lines are compared on the address with its low OFS_W bits dropped. This applies both to request lookups and to completion addresses.
- R3: A request whose line is valid in either table gets status 2 (aliased) and allocates nothing.
- R4: A request that does not alias gets status 3 (full) when the occupancy after this cycle's completions is at least `lim_out`, or when its own table has no free slot. Otherwise it gets status 1 (accepted) and the occupancy goes up by one. With no request, status is 0.
- R5: A refusal that hits the write-side table adds one to `stall_wq_rd` when the refused kind is 0, 1 or 3, and adds one to `stall_wq_wr` for any other kind.
- R6: A refusal that hits only the read-side table adds one to `stall_rq_wr` when the refused kind is 2 or 4, and adds one to `stall_rq_rd` for any other kind.
- R7: `deadlock` is sticky. It is never raised while every entry is younger than `age_lim` cycles. It is raised within 2*`age_lim`+3 cycles after any entry is accepted and then left outstanding.
- R8: A completion that matches an entry retires that entry and lowers `occupancy` by one. `occupancy` always equals the number of valid entries in both tables.
- R9: A completion with no matching entry in its table sets the sticky `proto_err` flag and leaves occupancy and all entries unchanged.
- R10: When a completion and a request fall in the same cycle, the completion is applied first. The freed line no longer aliases, the freed slot counts as free, and occupancy changes by the net amount.
- R11: After reset the occupancy is 0, both flags are low and all four stall counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_addr | input | AW | Request byte address |
| req_kind | input | 3 | Request kind code |
| req_status | output | 2 | 0 none, 1 accepted, 2 aliased, 3 full (combinational) |
| lim_out | input | OCC_W | Runtime limit on requests in flight |
| age_lim | input | TS_W | Deadlock age threshold in cycles (at least 1) |
| rd_done | input | 1 | Read-side completion strobe |
| rd_done_addr | input | AW | Address of the completed read-side line |
| wr_done | input | 1 | Write-side completion strobe |
| wr_done_addr | input | AW | Address of the completed write-side line |
| occupancy | output | OCC_W | Requests currently in flight |
| deadlock | output | 1 | Sticky stale-entry flag |
| proto_err | output | 1 | Sticky unmatched-completion flag |
| stall_wq_rd | output | CNT_W | Write-side aliasing refusals of kinds 0, 1 and 3 |
| stall_wq_wr | output | CNT_W | Write-side aliasing refusals of other kinds |
| stall_rq_wr | output | CNT_W | Read-side aliasing refusals of kinds 2 and 4 |
| stall_rq_rd | output | CNT_W | Read-side aliasing refusals of other kinds |

## Verification
The assertions assume that `lim_out` stays constant while a request is accepted, and that `age_lim` is at least 1 and far below half the timestamp range, so that modular ages never wrap. The age check also relies on no entry staying in flight for longer than that range. The stimulus changes `lim_out` and `age_lim` only while no request is being presented. It keeps the threshold at 10 or 1000 cycles, and every entry is retired after at most a few dozen cycles.

// File: rtl/trk_pkg.sv
package trk_pkg;

    typedef enum logic [2:0] {
        RQ_LOAD    = 3'd0,
        RQ_FETCH   = 3'd1,
        RQ_STORE   = 3'd2,
        RQ_RMW_RD  = 3'd3,
        RQ_RMW_WR  = 3'd4,
        RQ_LOCK_RD = 3'd5,
        RQ_LOCK_WR = 3'd6
    } rq_kind_e;

    typedef enum logic [1:0] {
        ST_NONE   = 2'd0,
        ST_ACCEPT = 2'd1,
        ST_ALIAS  = 2'd2,
        ST_FULL   = 2'd3
    } rq_status_e;

    typedef enum logic [1:0] {
        WD_IDLE = 2'd0,
        WD_RUN  = 2'd1,
        WD_SCAN = 2'd2
    } wd_state_e;

    // Kinds that belong in the write-side table.
    function automatic logic is_wr_class(input logic [2:0] k);
        return (k >= 3'd2) && (k <= 3'd6);
    endfunction

    // Kinds counted as load-like when a write-side entry blocks them.
    function automatic logic is_ld_like(input logic [2:0] k);
        return (k == RQ_LOAD) || (k == RQ_FETCH) || (k == RQ_RMW_RD);
    endfunction

    // Kinds counted as store-like when a read-side entry blocks them.
    function automatic logic is_st_like(input logic [2:0] k);
        return (k == RQ_STORE) || (k == RQ_RMW_WR);
    endfunction

endpackage

// File: rtl/trk_table.sv
module trk_table
    import trk_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int LA_W   = 26,
    parameter int TS_W   = 16,
    parameter bit WR_TBL = 1'b0,
    localparam int VC_W  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [LA_W-1:0] look_la,
    input  logic            alloc_en,
    input  logic [2:0]      alloc_kind,
    input  logic [TS_W-1:0] now_ts,
    input  logic            cmp_en,
    input  logic [LA_W-1:0] cmp_la,
    input  logic [TS_W-1:0] age_lim,
    output logic            look_hit,
    output logic            slot_free,
    output logic            cmp_hit,
    output logic [VC_W-1:0] vld_cnt,
    output logic            aged
);

    logic [DEPTH-1:0] vld_q;
    logic [LA_W-1:0]  la_q   [DEPTH];
    logic [2:0]       kind_q [DEPTH];
    logic [TS_W-1:0]  ts_q   [DEPTH];

    logic [DEPTH-1:0] m_look, m_cmp, clr, free_v, pick, old_v;

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_ent
            assign m_look[gi] = vld_q[gi] && (la_q[gi] == look_la);
            assign m_cmp[gi]  = vld_q[gi] && (la_q[gi] == cmp_la);
            assign old_v[gi]  = vld_q[gi] && ((now_ts - ts_q[gi]) >= age_lim);

            // R1
            // kind_class_chk: a valid entry always holds a kind of this table's class
            kind_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
                vld_q[gi] |-> (is_wr_class(kind_q[gi]) == WR_TBL));
        end
    endgenerate

    // Completion first: the cleared slot neither aliases nor counts as busy.
    assign clr       = cmp_en ? m_cmp : '0;
    assign free_v    = ~vld_q | clr;
    assign look_hit  = |(m_look & ~clr);
    assign slot_free = |free_v;
    assign cmp_hit   = |clr;
    assign aged      = |old_v;

    always_comb begin
        pick = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (free_v[i]) begin
                pick    = '0;
                pick[i] = 1'b1;
            end
        end
    end

    always_comb begin
        vld_cnt = '0;
        for (int i = 0; i < DEPTH; i++) begin
            vld_cnt = vld_cnt + VC_W'(vld_q[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (clr[i]) vld_q[i] <= 1'b0;
                if (alloc_en && pick[i]) vld_q[i] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (alloc_en && pick[i]) begin
                la_q[i]   <= look_la;
                kind_q[i] <= alloc_kind;
                ts_q[i]   <= now_ts;
            end
        end
    end

    // R3
    // line_unique_chk: a line is never held twice in one table
    line_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(m_look));

    // R4
    // alloc_room_chk: allocation only happens with a free slot
    alloc_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> slot_free);

    // R9
    // cmp_miss_chk: a completion with no match leaves the entry count alone
    cmp_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && !cmp_hit && !alloc_en) |=> (vld_cnt == $past(vld_cnt)));

endmodule

// File: rtl/trk_watchdog.sv
module trk_watchdog
    import trk_pkg::*;
#(
    parameter int TS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            busy,
    input  logic            any_aged,
    input  logic [TS_W-1:0] age_lim,
    output logic            dl_flag
);

    wd_state_e       state_q, state_d;
    logic [TS_W-1:0] timer_q;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WD_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: arm, expire, rearm, settle.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_IDLE: if (busy) state_d = WD_RUN;
            WD_RUN:  if (timer_q >= age_lim - TS_W'(1)) state_d = WD_SCAN;
            WD_SCAN: state_d = busy ? WD_RUN : WD_IDLE;
            default: state_d = WD_IDLE;
        endcase
    end

    // Outputs and the period timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timer_q <= '0;
            dl_flag <= 1'b0;
        end else begin
            timer_q <= (state_q == WD_RUN && state_d == WD_RUN) ? timer_q + TS_W'(1) : '0;
            if (state_q == WD_SCAN && any_aged) dl_flag <= 1'b1;
        end
    end

    // R7
    // dl_sticky_chk: the deadlock flag never drops once raised
    dl_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dl_flag |=> dl_flag);

    // R7
    // dl_origin_chk: the flag rises only at the end of a scan cycle
    dl_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dl_flag) |-> $past(state_q == WD_SCAN));

    // R7
    // scan_single_chk: a scan lasts exactly one cycle
    scan_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_SCAN) |=> (state_q != WD_SCAN));

endmodule

// File: rtl/trk_stall.sv
module trk_stall #(
    parameter int NCTR  = 4,
    parameter int CNT_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NCTR-1:0]             ev,
    output logic [NCTR-1:0][CNT_W-1:0]  cnt
);

    genvar gi;
    generate
        for (gi = 0; gi < NCTR; gi++) begin : g_ctr
            always_ff @(posedge clk) begin
                if (!rst_n)                       cnt[gi] <= '0;
                else if (ev[gi] && cnt[gi] != '1) cnt[gi] <= cnt[gi] + CNT_W'(1);
            end

            // R5
            // ctr_mono_chk: a counter never decreases
            ctr_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ##1 (cnt[gi] >= $past(cnt[gi])));
        end
    endgenerate

    // R6
    // ev_single_chk: at most one stall event per cycle
    ev_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ev));

endmodule

// File: rtl/req_tracker.sv
module req_tracker
    import trk_pkg::*;
#(
    parameter int AW    = 32,
    parameter int OFS_W = 6,
    parameter int DEPTH = 4,
    parameter int TS_W  = 16,
    parameter int CNT_W = 16,
    localparam int LA_W  = AW - OFS_W,
    localparam int OCC_W = $clog2(2 * DEPTH + 1),
    localparam int VC_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [AW-1:0]    req_addr,
    input  logic [2:0]       req_kind,
    output logic [1:0]       req_status,
    input  logic [OCC_W-1:0] lim_out,
    input  logic [TS_W-1:0]  age_lim,
    input  logic             rd_done,
    input  logic [AW-1:0]    rd_done_addr,
    input  logic             wr_done,
    input  logic [AW-1:0]    wr_done_addr,
    output logic [OCC_W-1:0] occupancy,
    output logic             deadlock,
    output logic             proto_err,
    output logic [CNT_W-1:0] stall_wq_rd,
    output logic [CNT_W-1:0] stall_wq_wr,
    output logic [CNT_W-1:0] stall_rq_wr,
    output logic [CNT_W-1:0] stall_rq_rd
);

    // Index 0 is the read-side table, index 1 the write-side table.
    logic [LA_W-1:0]  req_la;
    logic [LA_W-1:0]  done_la [2];
    logic [1:0]       done_v, look_hit, slot_free, cmp_hit, aged, alloc_en;
    logic [VC_W-1:0]  vcnt [2];
    logic [TS_W-1:0]  now_ts;
    logic [OCC_W-1:0] occ_q, occ_after;
    logic             tgt_wr, accept;
    rq_status_e       status;
    logic [3:0]       stall_ev;
    logic [3:0][CNT_W-1:0] stall_cnt;
    logic             unused_ofs;

    assign req_la     = req_addr[AW-1:OFS_W];
    assign done_la[0] = rd_done_addr[AW-1:OFS_W];
    assign done_la[1] = wr_done_addr[AW-1:OFS_W];
    assign done_v     = {wr_done, rd_done};
    assign unused_ofs = ^{req_addr[OFS_W-1:0], rd_done_addr[OFS_W-1:0], wr_done_addr[OFS_W-1:0]};
    assign tgt_wr     = is_wr_class(req_kind);

    genvar gc;
    generate
        for (gc = 0; gc < 2; gc++) begin : g_tbl
            trk_table #(
                .DEPTH (DEPTH),
                .LA_W  (LA_W),
                .TS_W  (TS_W),
                .WR_TBL(gc == 1)
            ) i_tbl (
                .clk       (clk),
                .rst_n     (rst_n),
                .look_la   (req_la),
                .alloc_en  (alloc_en[gc]),
                .alloc_kind(req_kind),
                .now_ts    (now_ts),
                .cmp_en    (done_v[gc]),
                .cmp_la    (done_la[gc]),
                .age_lim   (age_lim),
                .look_hit  (look_hit[gc]),
                .slot_free (slot_free[gc]),
                .cmp_hit   (cmp_hit[gc]),
                .vld_cnt   (vcnt[gc]),
                .aged      (aged[gc])
            );
        end
    endgenerate

    // Occupancy once this cycle's completions are applied.
    assign occ_after = occ_q - OCC_W'(cmp_hit[0]) - OCC_W'(cmp_hit[1]);

    always_comb begin
        status = ST_NONE;
        if (req_valid) begin
            if (look_hit[1] || look_hit[0])                        status = ST_ALIAS;
            else if (occ_after >= lim_out || !slot_free[tgt_wr])   status = ST_FULL;
            else                                                   status = ST_ACCEPT;
        end
    end

    assign accept      = (status == ST_ACCEPT);
    assign alloc_en[0] = accept && !tgt_wr;
    assign alloc_en[1] = accept && tgt_wr;
    assign req_status  = status;

    // Write-side hit takes priority in the stall accounting.
    assign stall_ev[0] = req_valid && look_hit[1] && is_ld_like(req_kind);
    assign stall_ev[1] = req_valid && look_hit[1] && !is_ld_like(req_kind);
    assign stall_ev[2] = req_valid && !look_hit[1] && look_hit[0] && is_st_like(req_kind);
    assign stall_ev[3] = req_valid && !look_hit[1] && look_hit[0] && !is_st_like(req_kind);

    trk_stall #(
        .NCTR (4),
        .CNT_W(CNT_W)
    ) i_stall (
        .clk  (clk),
        .rst_n(rst_n),
        .ev   (stall_ev),
        .cnt  (stall_cnt)
    );

    assign stall_wq_rd = stall_cnt[0];
    assign stall_wq_wr = stall_cnt[1];
    assign stall_rq_wr = stall_cnt[2];
    assign stall_rq_rd = stall_cnt[3];

    trk_watchdog #(
        .TS_W(TS_W)
    ) i_wd (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy    (occ_q != '0),
        .any_aged(|aged),
        .age_lim (age_lim),
        .dl_flag (deadlock)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now_ts    <= '0;
            occ_q     <= '0;
            proto_err <= 1'b0;
        end else begin
            now_ts <= now_ts + TS_W'(1);
            occ_q  <= occ_after + OCC_W'(accept);
            if ((rd_done && !cmp_hit[0]) || (wr_done && !cmp_hit[1])) proto_err <= 1'b1;
        end
    end

    assign occupancy = occ_q;

    // R8
    // occ_sum_chk: the occupancy matches the valid entries of both tables
    occ_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q == OCC_W'(vcnt[0]) + OCC_W'(vcnt[1]));

    // R4
    // occ_limit_chk: an accepted request never lifts occupancy past the limit
    occ_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_status == ST_ACCEPT) |=> (occ_q <= $past(lim_out)));

    // R10
    // net_change_chk: one completion plus one accept leaves occupancy level
    net_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_status == ST_ACCEPT) && $countones(cmp_hit) == 1) |=> (occ_q == $past(occ_q)));

    // R9
    // perr_sticky_chk: the protocol-error flag never drops once raised
    perr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

endmodule

// File: tb/test_req_tracker.sv
module test_req_tracker;

    localparam int AW    = 32;
    localparam int TS_W  = 16;
    localparam int CNT_W = 16;
    localparam int OCC_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [AW-1:0]    req_addr = '0;
    logic [2:0]       req_kind = '0;
    logic [1:0]       req_status;
    logic [OCC_W-1:0] lim_out = 4'd8;
    logic [TS_W-1:0]  age_lim = 16'd1000;
    logic             rd_done = 1'b0;
    logic [AW-1:0]    rd_done_addr = '0;
    logic             wr_done = 1'b0;
    logic [AW-1:0]    wr_done_addr = '0;
    logic [OCC_W-1:0] occupancy;
    logic             deadlock, proto_err;
    logic [CNT_W-1:0] stall_wq_rd, stall_wq_wr, stall_rq_wr, stall_rq_rd;

    int checks = 0;
    int fails  = 0;
    int e_wl = 0, e_ws = 0, e_rs = 0, e_rl = 0;

    always #2 clk = ~clk;

    req_tracker i_req_tracker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_kind(req_kind),
        .req_status(req_status), .lim_out(lim_out), .age_lim(age_lim),
        .rd_done(rd_done), .rd_done_addr(rd_done_addr),
        .wr_done(wr_done), .wr_done_addr(wr_done_addr),
        .occupancy(occupancy), .deadlock(deadlock), .proto_err(proto_err),
        .stall_wq_rd(stall_wq_rd), .stall_wq_wr(stall_wq_wr),
        .stall_rq_wr(stall_rq_wr), .stall_rq_rd(stall_rq_rd)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // All tasks start and end 1 ns after a rising edge.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic issue(input logic [31:0] a, input int k, input logic [1:0] es, input string tag);
        req_valid = 1'b1;
        req_addr  = a;
        req_kind  = 3'(k);
        #1;
        chk(tag, 32'(req_status), 32'(es));
        step();
        req_valid = 1'b0;
    endtask

    task automatic retire(input bit wr, input logic [31:0] a);
        if (wr) begin wr_done = 1'b1; wr_done_addr = a; end
        else    begin rd_done = 1'b1; rd_done_addr = a; end
        step();
        wr_done = 1'b0;
        rd_done = 1'b0;
    endtask

    task automatic chk_ctrs(input string tag);
        chk({tag, " wq_rd"}, 32'(stall_wq_rd), 32'(e_wl));
        chk({tag, " wq_wr"}, 32'(stall_wq_wr), 32'(e_ws));
        chk({tag, " rq_wr"}, 32'(stall_rq_wr), 32'(e_rs));
        chk({tag, " rq_rd"}, 32'(stall_rq_rd), 32'(e_rl));
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();
        // R11 reset state
        chk("R11 occupancy", 32'(occupancy), 0);
        chk("R11 deadlock", 32'(deadlock), 0);
        chk("R11 proto_err", 32'(proto_err), 0);
        chk("R11 status", 32'(req_status), 0);
        chk_ctrs("R11");

        // R1 R3 R5 R6 sweep: every holder kind against every requester kind
        for (int a = 0; a < 7; a++) begin
            for (int b = 0; b < 7; b++) begin
                logic [31:0] base;
                bit hw;
                base = 32'h0001_0000 + 32'((a * 7 + b) * 64);
                hw = (a >= 2);
                issue(base, a, 2'd1, "R1 holder accepted");
                chk("R1 occupancy one", 32'(occupancy), 1);
                issue(base + 32'd8, b, 2'd2, "R3 same line aliased");
                if (hw) begin
                    if (b == 0 || b == 1 || b == 3) e_wl++; else e_ws++;
                end else begin
                    if (b == 2 || b == 4) e_rs++; else e_rl++;
                end
                chk_ctrs(hw ? "R5" : "R6");
                retire(hw, base);
                chk("R8 retire to zero", 32'(occupancy), 0);
                chk("R1 class completion", 32'(proto_err), 0);
            end
        end

        // R2 offset bits ignored
        issue(32'h5000, 0, 2'd1, "R2 first line");
        issue(32'h503F, 2, 2'd2, "R2 same line other offset");
        e_rs++;
        issue(32'h5040, 0, 2'd1, "R2 next line");
        retire(1'b0, 32'h5011);
        chk("R2 completion offset ignored", 32'(occupancy), 1);
        retire(1'b0, 32'h5040);
        chk("R8 both retired", 32'(occupancy), 0);
        chk_ctrs("R2");

        // R4 limit and per-table room
        lim_out = 4'd3;
        issue(32'h6000, 0, 2'd1, "R4 a");
        issue(32'h6040, 1, 2'd1, "R4 b");
        issue(32'h6080, 2, 2'd1, "R4 c");
        issue(32'h60C0, 0, 2'd3, "R4 limit full");
        chk("R4 occupancy at limit", 32'(occupancy), 3);
        lim_out = 4'd8;
        issue(32'h60C0, 0, 2'd1, "R4 d after raise");
        issue(32'h6100, 1, 2'd1, "R4 e fourth read");
        issue(32'h6140, 0, 2'd3, "R4 read table full");
        issue(32'h6180, 6, 2'd1, "R4 write side still open");
        chk("R4 occupancy six", 32'(occupancy), 6);
        chk_ctrs("R4");
        retire(1'b0, 32'h6000);
        retire(1'b0, 32'h6040);
        retire(1'b1, 32'h6080);
        retire(1'b0, 32'h60C0);
        retire(1'b0, 32'h6100);
        retire(1'b1, 32'h6180);
        chk("R8 drained", 32'(occupancy), 0);

        // R10 completion applied before a same-cycle request
        lim_out = 4'd2;
        issue(32'h7000, 0, 2'd1, "R10 a");
        issue(32'h7040, 2, 2'd1, "R10 b");
        rd_done = 1'b1; rd_done_addr = 32'h7000;
        issue(32'h7080, 1, 2'd1, "R10 freed count admits");
        rd_done = 1'b0;
        chk("R10 net zero", 32'(occupancy), 2);
        rd_done = 1'b1; rd_done_addr = 32'h7080;
        issue(32'h7080, 4, 2'd1, "R10 freed line no alias");
        rd_done = 1'b0;
        chk("R10 net zero again", 32'(occupancy), 2);
        chk_ctrs("R10");
        retire(1'b1, 32'h7040);
        retire(1'b1, 32'h7080);
        chk("R10 drained", 32'(occupancy), 0);
        chk("R10 no proto error", 32'(proto_err), 0);
        lim_out = 4'd8;

        // R7 deadlock window
        age_lim = 16'd10;
        issue(32'h8000, 0, 2'd1, "R7 short-lived");
        repeat (5) step();
        retire(1'b0, 32'h8000);
        repeat (40) step();
        chk("R7 no flag for young entry", 32'(deadlock), 0);
        issue(32'h8040, 2, 2'd1, "R7 stuck entry");
        repeat (8) step();
        chk("R7 not before threshold", 32'(deadlock), 0);
        repeat (20) step();
        chk("R7 flag raised", 32'(deadlock), 1);
        retire(1'b1, 32'h8040);
        repeat (3) step();
        chk("R7 flag sticky", 32'(deadlock), 1);
        age_lim = 16'd1000;

        // R9 unmatched completion
        chk("R9 clean before", 32'(proto_err), 0);
        issue(32'h9000, 0, 2'd1, "R9 holder");
        retire(1'b1, 32'h9000);
        chk("R9 wrong table flagged", 32'(proto_err), 1);
        chk("R9 entry kept", 32'(occupancy), 1);
        issue(32'h9000, 0, 2'd2, "R9 line still held");
        e_rl++;
        retire(1'b0, 32'hA000);
        chk("R9 unknown line no change", 32'(occupancy), 1);
        retire(1'b0, 32'h9000);
        chk("R9 flag sticky", 32'(proto_err), 1);
        chk("R8 final drain", 32'(occupancy), 0);
        chk_ctrs("R9");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule